// File: doc/BRIEF.md
# Channel Enable Mask and Test-Pulse Train Generator

This block sits in front of a bank of delay-line multiplexer inputs. It holds one enable bit per input channel and can inject trains of test pulses into a contiguous band of channels, for example to check cable connections. The test-pulse vector is meant to be ORed with the live detector inputs. Downstream, the mask vector gates both the live inputs and the test pulses.

All settings sit in byte-wide registers behind a simple parallel write port made of an address, a data byte and a write strobe. This port stands in for a serial slave interface. A software-issued start command launches one train. The train uses a programmed pulse count, a pulse high time and a pulse period, both given in clock cycles. A busy output is high while a train is in progress.

The test-pulse output is combinational from the sequencer state and the live range and mask registers. Every register update becomes visible on the cycle after the write edge.

Top module: `chan_mask_pulse_ctl`

## Requirements
- R1: Mask bytes sit at addresses 0 to 4. A write to address k loads wrData into mask bits [8k+7:8k], and only the bits that exist (35:32 for address 4) are kept. maskOut shows the new value in the cycle after the write edge, and a mask bit of 1 enables its channel.
- R2: After reset, maskOut is all ones, busy is 0 and pulseOut is all zeros. The first channel is 0, the last channel is 35, the pulse count is 1, the high time is 1 and the period is 2.
- R3: Writing address 11 with bit 0 set is a start command. When the block is idle, the stored count (address 7 low byte, address 8 high byte) is non-zero and the period (address 10) is non-zero, busy rises in the cycle after the write edge. It then stays high for exactly count × period cycles, and pulseOut is zero whenever busy is low.
- R4: In each period of a train, the selected channels are high for the first min(high, period) cycles, where high is the value at address 9. A high time of 0 gives no pulses.
- R5: Only channels whose index i satisfies first ≤ i ≤ last are driven, with first at address 5 and last at address 6. An index for last above 35 simply covers the channels up to 35.
- R6: If first > last, no channel is driven, yet the train still runs its full length with busy high.
- R7: A channel whose mask bit is 0 never carries a test pulse.
- R8: A start command written while busy is ignored, and the running train keeps its length and pulse pattern.
- R9: A start command with a count of 0 or a period of 0 is ignored, and busy stays low.
- R10: Count, high time and period are captured at start. Writing those registers during a train does not change the running train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| maskOut | output | 36 | Channel enable mask, 1 = enabled |
| pulseOut | output | 36 | Masked test-pulse vector |
| busy | output | 1 | Train in progress |

## Verification
Register writes land at the write edge, so maskOut is sampled on the falling edge after that edge.

For a start command, train cycle 0 is the first falling edge after the start edge. At cycle c the bench expects busy to be high when c < count × period. It expects pulseOut to equal the masked range vector when, in addition, c mod period < high. Both are checked at every falling edge up to and including cycle count × period, where busy must be low.

Stimulus written during a train, such as a second start or a new period, is driven at one falling edge and withdrawn at the next. The same per-cycle expectation continues across it, so any effect of that write would show up as a miscompare.

// File: rtl/cmtp_pkg.sv
package cmtp_pkg;
  // Register addresses; mask bytes occupy 0..4.
  localparam int REG_FIRST  = 5;
  localparam int REG_LAST   = 6;
  localparam int REG_CNT_LO = 7;
  localparam int REG_CNT_HI = 8;
  localparam int REG_HIGH   = 9;
  localparam int REG_PERIOD = 10;
  localparam int REG_CTRL   = 11;

  // Strobes from the train sequencer to the register/datapath side.
  typedef struct packed {
    logic active;
    logic pulseOn;
  } trainStb_t;
endpackage

// File: rtl/cmtp_range_dec.sv
module cmtp_range_dec #(
  parameter int NUM_CH = 36,
  parameter int IDX_W  = 8
) (
  input  logic [IDX_W-1:0]  firstIdx,
  input  logic [IDX_W-1:0]  lastIdx,
  output logic [NUM_CH-1:0] selVec
);
  // One pair of comparators per channel; empty when first > last.
  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    assign selVec[i] = (firstIdx <= IDX_W'(i)) && (IDX_W'(i) <= lastIdx);
  end
endmodule

// File: rtl/cmtp_seq.sv
module cmtp_seq
  import cmtp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [TIME_W-1:0] cfgHigh,
  input  logic [TIME_W-1:0] cfgPeriod,
  output trainStb_t         stb,
  output logic              busy
);
  logic [TIME_W-1:0] phase, highL, perL;
  logic [CNT_W-1:0]  idx, cntL;
  logic              accept, lastPhase, lastPulse;

  assign accept    = startReq && !busy && (cfgCount != '0) && (cfgPeriod != '0);
  assign lastPhase = (phase == perL - 1'b1);
  assign lastPulse = (idx == cntL - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
      idx   <= '0;
      cntL  <= '0;
      highL <= '0;
      perL  <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
      idx   <= '0;
      cntL  <= cfgCount;
      highL <= cfgHigh;
      perL  <= cfgPeriod;
    end else if (busy) begin
      if (lastPhase) begin
        phase <= '0;
        if (lastPulse) busy <= 1'b0;
        else           idx  <= idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign stb.active  = busy;
  assign stb.pulseOn = busy && (phase < highL);
endmodule

// File: rtl/cmtp_regs.sv
module cmtp_regs
  import cmtp_pkg::*;
#(
  parameter int NUM_CH = 36,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  trainStb_t         stb,
  output logic              startReq,
  output logic [CNT_W-1:0]  cfgCount,
  output logic [TIME_W-1:0] cfgHigh,
  output logic [TIME_W-1:0] cfgPeriod,
  output logic [NUM_CH-1:0] maskOut,
  output logic [NUM_CH-1:0] pulseOut
);
  localparam int MASK_BYTES = (NUM_CH + 7) / 8;
  localparam int IDX_W      = 8;

  logic [NUM_CH-1:0] maskReg;
  logic [IDX_W-1:0]  firstIdx, lastIdx;
  logic [7:0]        cntLo, cntHi;
  logic [NUM_CH-1:0] selVec;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  // Mask storage: one byte lane per address, partial top lane.
  for (genvar b = 0; b < MASK_BYTES; b++) begin : gByte
    localparam int LO = b * 8;
    localparam int HI = (LO + 8 > NUM_CH) ? NUM_CH - 1 : LO + 7;
    always_ff @(posedge clk) begin
      if (!rstN)                        maskReg[HI:LO] <= '1;
      else if (wrEn && hit(wrAddr, b))  maskReg[HI:LO] <= wrData[HI-LO:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstIdx  <= '0;
      lastIdx   <= IDX_W'(NUM_CH - 1);
      cntLo     <= 8'd1;
      cntHi     <= 8'd0;
      cfgHigh   <= TIME_W'(1);
      cfgPeriod <= TIME_W'(2);
    end else if (wrEn) begin
      if (hit(wrAddr, REG_FIRST))  firstIdx  <= wrData;
      if (hit(wrAddr, REG_LAST))   lastIdx   <= wrData;
      if (hit(wrAddr, REG_CNT_LO)) cntLo     <= wrData;
      if (hit(wrAddr, REG_CNT_HI)) cntHi     <= wrData;
      if (hit(wrAddr, REG_HIGH))   cfgHigh   <= TIME_W'(wrData);
      if (hit(wrAddr, REG_PERIOD)) cfgPeriod <= TIME_W'(wrData);
    end
  end

  assign cfgCount = CNT_W'({cntHi, cntLo});
  assign startReq = wrEn && hit(wrAddr, REG_CTRL) && wrData[0];

  cmtp_range_dec #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) rangeDec_i (
    .firstIdx(firstIdx),
    .lastIdx (lastIdx),
    .selVec  (selVec)
  );

  assign maskOut  = maskReg;
  assign pulseOut = (stb.active && stb.pulseOn) ? (selVec & maskReg) : '0;
endmodule

// File: rtl/chan_mask_pulse_ctl.sv
module chan_mask_pulse_ctl
  import cmtp_pkg::*;
#(
  parameter int NUM_CH = 36,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [NUM_CH-1:0] maskOut,
  output logic [NUM_CH-1:0] pulseOut,
  output logic              busy
);
  trainStb_t         stb;
  logic              startReq;
  logic [CNT_W-1:0]  cfgCount;
  logic [TIME_W-1:0] cfgHigh, cfgPeriod;

  cmtp_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .startReq(startReq), .cfgCount(cfgCount), .cfgHigh(cfgHigh),
    .cfgPeriod(cfgPeriod), .maskOut(maskOut), .pulseOut(pulseOut)
  );

  cmtp_seq #(.CNT_W(CNT_W), .TIME_W(TIME_W)) seq_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgCount(cfgCount),
    .cfgHigh(cfgHigh), .cfgPeriod(cfgPeriod), .stb(stb), .busy(busy)
  );
endmodule

// File: rtl/chan_mask_pulse_chk.sv
module chan_mask_pulse_chk
  import cmtp_pkg::*;
#(
  parameter int NUM_CH = 36,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [NUM_CH-1:0] maskOut,
  input logic [NUM_CH-1:0] pulseOut,
  input logic              busy
);
  // Shadow copies rebuilt from the write port alone.
  logic [7:0]        firstS, lastS, cntLoS, cntHiS;
  logic [NUM_CH-1:0] rangeS;
  logic              startWr;

  assign startWr = wrEn && (wrAddr == ADDR_W'(REG_CTRL)) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstS <= '0; lastS <= 8'(NUM_CH - 1); cntLoS <= 8'd1; cntHiS <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(REG_FIRST))  firstS <= wrData;
      if (wrAddr == ADDR_W'(REG_LAST))   lastS  <= wrData;
      if (wrAddr == ADDR_W'(REG_CNT_LO)) cntLoS <= wrData;
      if (wrAddr == ADDR_W'(REG_CNT_HI)) cntHiS <= wrData;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      rangeS[i] = (int'(firstS) <= i) && (i <= int'(lastS));
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pulseOut == '0)); // R3
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr)); // R3
  AST_RANGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut == '0) || (pulseOut == (rangeS & maskOut))); // R5
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut & ~maskOut) == '0); // R7
  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startWr && ({cntHiS, cntLoS} == 16'd0)) |=> !busy); // R9
endmodule

bind chan_mask_pulse_ctl chan_mask_pulse_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .maskOut(maskOut), .pulseOut(pulseOut), .busy(busy)
);

// File: tb/chan_mask_pulse_ctl_tb_top.sv
module chan_mask_pulse_ctl_tb_top;
  localparam int N = 36;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic [N-1:0] maskOut, pulseOut;
  logic         busy;

  int vecCnt = 0;
  int errCnt = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  chan_mask_pulse_ctl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .maskOut(maskOut), .pulseOut(pulseOut), .busy(busy)
  );

  function automatic logic [N-1:0] rangeVec(input int f, input int l, input logic [N-1:0] m);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i >= f) && (i <= l) && m[i];
    return v;
  endfunction

  task automatic chkVec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 8'(d);
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic setCfg(input int f, input int l, input int cnt, input int hi, input int per);
    wr(5, f); wr(6, l); wr(7, cnt & 255); wr(8, cnt >> 8); wr(9, hi); wr(10, per);
  endtask

  // Issues start, then checks every cycle; optional extra write at cycle reAt.
  task automatic runTrain(input string req, input logic [N-1:0] exp, input int cnt,
                          input int hi, input int per, input int reAt,
                          input int reAddr, input int reData);
    int total = cnt * per;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd11; wrData = 8'd1;
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      wrEn = 1'b0;
      chkBit({req, " busy"}, busy, c < total);
      chkVec({req, " pulse"}, pulseOut,
             ((c < total) && ((c % per) < hi)) ? exp : '0);
      if (c == reAt) begin
        wrEn = 1'b1; wrAddr = 4'(reAddr); wrData = 8'(reData);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      errCnt++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m;
    logic [N-1:0] expMask;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chkVec("R2 mask reset", maskOut, '1);
    chkBit("R2 busy reset", busy, 1'b0);
    chkVec("R2 pulse reset", pulseOut, '0);

    // R2: reset configuration drives a 1-pulse, high 1, period 2 train on all channels
    runTrain("R2 default train", '1, 1, 1, 2, -1, 0, 0);

    // R1 mask byte lanes
    expMask = '1;
    for (int k = 0; k < 5; k++) begin
      int v = (k * 8'h37 + 8'h5A) & 255;
      wr(k, v);
      for (int b = 0; b < 8; b++)
        if (k * 8 + b < N) expMask[k * 8 + b] = v[b];
      @(negedge clk);
      chkVec("R1 mask write", maskOut, expMask);
    end
    wr(4, 8'hFF);
    expMask[35:32] = 4'hF;
    @(negedge clk);
    chkVec("R1 top lane upper bits dropped", maskOut, expMask);
    m = expMask;

    // R3 R4 R5 R7 sweep over ranges and timing settings
    for (int r = 0; r < 5; r++) begin
      int f = (r == 0) ? 0 : (r == 1) ? 3 : (r == 2) ? 35 : (r == 3) ? 0 : 10;
      int l = (r == 0) ? 35 : (r == 1) ? 9 : (r == 2) ? 35 : (r == 3) ? 0 : 50;
      for (int cnt = 1; cnt <= 3; cnt++)
        for (int hi = 0; hi <= 3; hi++)
          for (int per = 1; per <= 3; per++) begin
            setCfg(f, l, cnt, hi, per);
            runTrain("R3 R4 R5 R7 sweep", rangeVec(f, l, m), cnt, hi, per, -1, 0, 0);
          end
    end

    // R7 all lanes masked off
    for (int k = 0; k < 5; k++) wr(k, 0);
    setCfg(0, 35, 2, 2, 3);
    runTrain("R7 fully masked", '0, 2, 2, 3, -1, 0, 0);
    for (int k = 0; k < 5; k++) wr(k, 8'hFF);
    m = '1;

    // R6 inverted range
    setCfg(20, 5, 2, 1, 3);
    runTrain("R6 first above last", '0, 2, 1, 3, -1, 0, 0);

    // R8 second start mid-train ignored
    setCfg(4, 12, 2, 2, 4);
    runTrain("R8 restart ignored", rangeVec(4, 12, m), 2, 2, 4, 2, 11, 1);

    // R10 period rewritten mid-train
    setCfg(0, 7, 3, 1, 3);
    runTrain("R10 period captured", rangeVec(0, 7, m), 3, 1, 3, 1, 10, 1);
    setCfg(0, 7, 3, 1, 3);
    runTrain("R10 count captured", rangeVec(0, 7, m), 3, 1, 3, 3, 7, 9);

    // R3 16-bit count uses the high byte
    setCfg(0, 35, 260, 1, 1);
    runTrain("R3 long count", m, 260, 1, 1, -1, 0, 0);

    // R9 zero count and zero period
    for (int z = 0; z < 2; z++) begin
      setCfg(0, 35, (z == 0) ? 0 : 2, 1, (z == 0) ? 2 : 0);
      wr(11, 1);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chkBit("R9 zero setting busy", busy, 1'b0);
        chkVec("R9 zero setting pulse", pulseOut, '0);
      end
    end

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule